// File: doc/BRIEF.md
# Bank-Group Embedding Gather-Reduce Unit

This unit sits beside one DRAM bank group and accumulates compositional embedding lookups. A logical embedding index is split into a quotient index, whose vector is read from the bank group over a request/response port, and a remainder index, whose vector is read from an on-chip table. That table holds the entire remainder table and is filled through its own write port before any lookup is issued. The unit adds the two vectors lane by lane into the accumulator of the lookup's batch slot.

Up to four batch slots accumulate at the same time. Their lookups may interleave, and bank responses may return out of order. A batch ends with an instruction that carries the last flag. Once that instruction's bank data has been added, the slot's partial sum is offered on a valid/ready output toward a second-level reducer. The slot becomes free again only after that result has been accepted. Because addition is associative, the partial sum does not depend on where the matching vectors of a lookup live.

Top module: `bg_embed_reduce`

## Requirements
- R1: While reset is held and in the first cycle after it, `ps_valid` and `bank_req_valid` are low and `instr_ready` is high.
- R2: `instr_word` is laid out as {last, slot, index}: index in bits [IDX_W-1:0], slot in the next SLOT_W bits, last flag in the top bit. The low log2(REM_CNT) index bits select the remainder-table entry. The remaining high bits appear as `bank_req_addr`.
- R3: Each accepted instruction causes exactly one bank request. The remainder vector is never fetched through the bank port.
- R4: `bank_req_tag` equals the slot field of the instruction that caused the request, and `bank_rsp_tag` selects the slot whose accumulator takes the response.
- R5: A slot's partial sum is, for each lane i at bits [16i+15:16i], the sum of quotient lane i plus remainder lane i over all lookups of the batch, taken modulo 2^16.
- R6: Slots accumulate independently when lookups for different slots interleave and responses return in an order different from the requests.
- R7: A slot's partial sum is offered only after the bank response of its last-flagged lookup has been added. `ps_slot` names the slot.
- R8: While `ps_valid` is high and `ps_ready` is low, `ps_valid`, `ps_slot` and `ps_data` hold their values.
- R9: A closed slot accepts no new lookup until its partial sum is accepted. The slot's next batch then starts from zero.
- R10: While `lut_we` is high, `instr_ready` is low and no instruction is accepted.
- R11: A slot has at most one bank request outstanding. A further lookup for that slot waits until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_we | input | 1 | Remainder table write strobe |
| lut_addr | input | REM_W | Remainder table write entry |
| lut_wdata | input | VEC_W | Remainder vector to store |
| instr_valid | input | 1 | Lookup instruction offered |
| instr_ready | output | 1 | Instruction register can take a word |
| instr_word | input | WORD_W | {last, slot, index} |
| bank_req_valid | output | 1 | Quotient vector read request |
| bank_req_ready | input | 1 | Bank takes the request |
| bank_req_addr | output | Q_W | Quotient row index |
| bank_req_tag | output | SLOT_W | Requesting slot |
| bank_rsp_valid | input | 1 | Quotient vector returned |
| bank_rsp_tag | input | SLOT_W | Slot the data belongs to |
| bank_rsp_data | input | VEC_W | Quotient vector lanes |
| ps_valid | output | 1 | Partial sum offered |
| ps_ready | input | 1 | Reducer takes the partial sum |
| ps_slot | output | SLOT_W | Slot of the partial sum |
| ps_data | output | VEC_W | Partial sum lanes |

## Verification
The bench builds the unit with its defaults: a 12-bit index, a 16-entry remainder table, four slots and eight 16-bit lanes. With these values, index 4095 reaches the top quotient row 255 and remainder entry 15. All four slots can be kept open together, which brings out-of-order responses across every tag within reach. The table and bank contents are chosen near 0x8000 and 0xF000, so that lane sums wrap on every lookup. Stalls on the bank request and on the output handshake expose the holding rule, the one-outstanding-per-slot rule and slot reuse.

// File: rtl/gr_pkg.sv
package gr_pkg;

  // Life cycle of one batch slot.
  typedef enum logic [1:0] {
    SLOT_OPEN   = 2'd0,  // accepting lookups (accumulator may be zero)
    SLOT_CLOSED = 2'd1,  // last lookup issued, waiting on its bank data
    SLOT_DRAIN  = 2'd2   // partial sum presented on the output port
  } slot_state_e;

endpackage

// File: rtl/gr_instr_reg.sv
module gr_instr_reg #(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned REM_W  = 4,
  parameter int unsigned SLOT_W = 2,
  localparam int unsigned Q_W    = IDX_W - REM_W,
  localparam int unsigned WORD_W = IDX_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              load_busy,
  input  logic              take,
  output logic              instr_ready,
  output logic              ir_valid,
  output logic [Q_W-1:0]    dec_q,
  output logic [REM_W-1:0]  dec_r,
  output logic [SLOT_W-1:0] dec_slot,
  output logic              dec_last
);

  logic [WORD_W-1:0] ir_word;

  assign instr_ready = !load_busy && (!ir_valid || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_valid <= 1'b0;
      ir_word  <= '0;
    end else if (instr_valid && instr_ready) begin
      ir_valid <= 1'b1;
      ir_word  <= instr_word;
    end else if (take) begin
      ir_valid <= 1'b0;
    end
  end

  // Decoder: field split of the held word.
  assign dec_r    = ir_word[REM_W-1:0];
  assign dec_q    = ir_word[IDX_W-1:REM_W];
  assign dec_slot = ir_word[IDX_W +: SLOT_W];
  assign dec_last = ir_word[WORD_W-1];

endmodule

// File: rtl/gr_rem_lut.sv
module gr_rem_lut #(
  parameter int unsigned REM_CNT = 16,
  parameter int unsigned VEC_W   = 128,
  localparam int unsigned REM_W  = $clog2(REM_CNT)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [REM_W-1:0] waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [REM_W-1:0] raddr,
  output logic [VEC_W-1:0] rdata
);

  logic [VEC_W-1:0] mem [REM_CNT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/gr_slot_acc.sv
module gr_slot_acc #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   issue_fire,
  input  logic [SLOT_W-1:0]      issue_slot,
  input  logic [VEC_W-1:0]       issue_rvec,
  input  logic                   rsp_valid,
  input  logic [SLOT_W-1:0]      rsp_tag,
  input  logic [VEC_W-1:0]       rsp_data,
  input  logic                   clear_en,
  input  logic [SLOT_W-1:0]      clear_slot,
  output logic [SLOTS*VEC_W-1:0] acc_flat,
  output logic [SLOTS-1:0]       pending,
  output logic                   rsp_used
);

  // Lane-wise three-input sum, each lane wrapping at 2^LANE_W.
  function automatic logic [VEC_W-1:0] lane_sum3(input logic [VEC_W-1:0] a,
                                                 input logic [VEC_W-1:0] b,
                                                 input logic [VEC_W-1:0] c);
    logic [VEC_W-1:0] s;
    for (int i = 0; i < LANES; i++) begin
      s[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W]
                            + c[i*LANE_W +: LANE_W];
    end
    return s;
  endfunction

  assign rsp_used = rsp_valid && pending[rsp_tag];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [VEC_W-1:0] acc_q;
    logic [VEC_W-1:0] rem_q;
    logic             pend_q;
    logic             hit_rsp;
    logic             hit_issue;
    logic             hit_clr;

    assign hit_rsp   = rsp_valid  && (rsp_tag    == SLOT_W'(s));
    assign hit_issue = issue_fire && (issue_slot == SLOT_W'(s));
    assign hit_clr   = clear_en   && (clear_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q  <= '0;
        rem_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        if (hit_clr)
          acc_q <= '0;
        else if (hit_rsp && pend_q)
          acc_q <= lane_sum3(acc_q, rsp_data, rem_q);
        if (hit_issue) begin
          rem_q  <= issue_rvec;
          pend_q <= 1'b1;
        end else if (hit_rsp) begin
          pend_q <= 1'b0;
        end
      end
    end

    assign acc_flat[s*VEC_W +: VEC_W] = acc_q;
    assign pending[s]                 = pend_q;
  end

endmodule

// File: rtl/bg_embed_reduce.sv
module bg_embed_reduce import gr_pkg::*; #(
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned REM_CNT = 16,
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 16,
  localparam int unsigned REM_W  = $clog2(REM_CNT),
  localparam int unsigned Q_W    = IDX_W - REM_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned VEC_W  = LANES * LANE_W,
  localparam int unsigned WORD_W = IDX_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lut_we,
  input  logic [REM_W-1:0]  lut_addr,
  input  logic [VEC_W-1:0]  lut_wdata,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [WORD_W-1:0] instr_word,
  output logic              bank_req_valid,
  input  logic              bank_req_ready,
  output logic [Q_W-1:0]    bank_req_addr,
  output logic [SLOT_W-1:0] bank_req_tag,
  input  logic              bank_rsp_valid,
  input  logic [SLOT_W-1:0] bank_rsp_tag,
  input  logic [VEC_W-1:0]  bank_rsp_data,
  output logic              ps_valid,
  input  logic              ps_ready,
  output logic [SLOT_W-1:0] ps_slot,
  output logic [VEC_W-1:0]  ps_data
);

  // Named internal events, also observed by the checker.
  logic                   ir_valid;
  logic                   dec_last;
  logic [Q_W-1:0]         dec_q;
  logic [REM_W-1:0]       dec_r;
  logic [SLOT_W-1:0]      dec_slot;
  logic                   issue_ok;
  logic                   issue_fire;
  logic                   rsp_used;
  logic                   pick_valid;
  logic [SLOT_W-1:0]      pick_idx;
  logic                   out_busy;
  logic [SLOT_W-1:0]      out_sel;
  logic                   ps_fire;
  logic [VEC_W-1:0]       rem_vec;
  logic [SLOTS*VEC_W-1:0] acc_flat;
  logic [SLOTS-1:0]       pending;
  slot_state_e            st [SLOTS];

  gr_instr_reg #(.IDX_W(IDX_W), .REM_W(REM_W), .SLOT_W(SLOT_W)) u_ir (
    .clk(clk), .rst(rst),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .load_busy(lut_we), .take(issue_fire),
    .instr_ready(instr_ready), .ir_valid(ir_valid),
    .dec_q(dec_q), .dec_r(dec_r), .dec_slot(dec_slot), .dec_last(dec_last)
  );

  gr_rem_lut #(.REM_CNT(REM_CNT), .VEC_W(VEC_W)) u_lut (
    .clk(clk), .we(lut_we), .waddr(lut_addr), .wdata(lut_wdata),
    .raddr(dec_r), .rdata(rem_vec)
  );

  gr_slot_acc #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .LANES(LANES), .LANE_W(LANE_W)) u_acc (
    .clk(clk), .rst(rst),
    .issue_fire(issue_fire), .issue_slot(dec_slot), .issue_rvec(rem_vec),
    .rsp_valid(bank_rsp_valid), .rsp_tag(bank_rsp_tag), .rsp_data(bank_rsp_data),
    .clear_en(ps_fire), .clear_slot(out_sel),
    .acc_flat(acc_flat), .pending(pending), .rsp_used(rsp_used)
  );

  // Issue: only the quotient row goes to the bank; remainder is captured locally.
  assign issue_ok       = ir_valid && !lut_we && (st[dec_slot] == SLOT_OPEN) && !pending[dec_slot];
  assign issue_fire     = issue_ok && bank_req_ready;
  assign bank_req_valid = issue_ok;
  assign bank_req_addr  = dec_q;
  assign bank_req_tag   = dec_slot;

  // Lowest-numbered slot whose last data has landed.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (st[s] == SLOT_CLOSED && !pending[s]) begin
        pick_valid = 1'b1;
        pick_idx   = SLOT_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_busy <= 1'b0;
      out_sel  <= '0;
      for (int s = 0; s < SLOTS; s++) st[s] <= SLOT_OPEN;
    end else begin
      if (issue_fire && dec_last) st[dec_slot] <= SLOT_CLOSED;
      if (!out_busy && pick_valid) begin
        st[pick_idx] <= SLOT_DRAIN;
        out_busy     <= 1'b1;
        out_sel      <= pick_idx;
      end else if (ps_fire) begin
        st[out_sel] <= SLOT_OPEN;
        out_busy    <= 1'b0;
      end
    end
  end

  assign ps_fire  = out_busy && ps_ready;
  assign ps_valid = out_busy;
  assign ps_slot  = out_sel;

  always_comb begin
    ps_data = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (out_sel == SLOT_W'(s)) ps_data = acc_flat[s*VEC_W +: VEC_W];
    end
  end

endmodule

// File: rtl/gr_checker.sv
module gr_checker #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned VEC_W  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              lut_we,
  input logic              instr_ready,
  input logic              bank_req_valid,
  input logic              bank_req_ready,
  input logic [SLOT_W-1:0] bank_req_tag,
  input logic              bank_rsp_valid,
  input logic [SLOT_W-1:0] bank_rsp_tag,
  input logic              ps_valid,
  input logic              ps_ready,
  input logic [SLOT_W-1:0] ps_slot,
  input logic [VEC_W-1:0]  ps_data
);

  // Outstanding-request tracker built from the port handshakes alone.
  logic [SLOTS-1:0] trk;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (bank_req_valid && bank_req_ready && bank_req_tag == SLOT_W'(s))
          trk[s] <= 1'b1;
        else if (bank_rsp_valid && bank_rsp_tag == SLOT_W'(s))
          trk[s] <= 1'b0;
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ps_valid && !bank_req_valid && instr_ready));

  a_r8_output_held: assert property (@(posedge clk) disable iff (rst)
    (ps_valid && !ps_ready) |=> (ps_valid && $stable(ps_slot) && $stable(ps_data)));

  a_r10_load_blocks_instr: assert property (@(posedge clk) disable iff (rst)
    lut_we |-> !instr_ready);

  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    bank_req_valid |-> !trk[bank_req_tag]);

  a_r7_sum_after_data: assert property (@(posedge clk) disable iff (rst)
    ps_valid |-> !trk[ps_slot]);

endmodule

bind bg_embed_reduce gr_checker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .lut_we(lut_we), .instr_ready(instr_ready),
  .bank_req_valid(bank_req_valid), .bank_req_ready(bank_req_ready), .bank_req_tag(bank_req_tag),
  .bank_rsp_valid(bank_rsp_valid), .bank_rsp_tag(bank_rsp_tag),
  .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_slot(ps_slot), .ps_data(ps_data)
);

// File: tb/tb_bg_embed_reduce.sv
module tb_bg_embed_reduce;

  localparam int SL = 4;
  localparam int LN = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lut_we = 1'b0;
  logic [3:0]   lut_addr = '0;
  logic [127:0] lut_wdata = '0;
  logic         instr_valid = 1'b0;
  logic         instr_ready;
  logic [14:0]  instr_word = '0;
  logic         bank_req_valid;
  logic         bank_req_ready = 1'b0;
  logic [7:0]   bank_req_addr;
  logic [1:0]   bank_req_tag;
  logic         bank_rsp_valid = 1'b0;
  logic [1:0]   bank_rsp_tag = '0;
  logic [127:0] bank_rsp_data = '0;
  logic         ps_valid;
  logic         ps_ready = 1'b0;
  logic [1:0]   ps_slot;
  logic [127:0] ps_data;

  bg_embed_reduce dut (
    .clk(clk), .rst(rst), .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .bank_req_valid(bank_req_valid), .bank_req_ready(bank_req_ready),
    .bank_req_addr(bank_req_addr), .bank_req_tag(bank_req_tag),
    .bank_rsp_valid(bank_rsp_valid), .bank_rsp_tag(bank_rsp_tag), .bank_rsp_data(bank_rsp_data),
    .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_slot(ps_slot), .ps_data(ps_data)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_instr = 0;
  int n_req = 0;
  bit bank_stall = 1'b0;
  bit out_stall = 1'b0;
  bit done_flag = 1'b0;

  int           qexp   [SL][$];
  logic [127:0] done_q [SL][$];
  logic [127:0] run_acc [SL];
  bit           act [SL];
  int           cnt [SL];
  int           adr [SL];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act_v,
                       input logic [127:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [15:0] qlane(input int q, input int l);
    return 16'((q * 37 + l * 1009 + 61440) % 65536);
  endfunction

  function automatic logic [15:0] rlane(input int r, input int l);
    return 16'((r * 4099 + l * 77 + 32768) % 65536);
  endfunction

  function automatic logic [127:0] qvec(input int q);
    logic [127:0] v;
    for (int l = 0; l < LN; l++) v[l*16 +: 16] = qlane(q, l);
    return v;
  endfunction

  function automatic logic [127:0] rvec(input int r);
    logic [127:0] v;
    for (int l = 0; l < LN; l++) v[l*16 +: 16] = rlane(r, l);
    return v;
  endfunction

  // Bank model: variable latency per tag, responses out of order.
  initial begin
    for (int t = 0; t < SL; t++) begin act[t] = 1'b0; cnt[t] = 0; adr[t] = 0; end
    forever begin
      bit found;
      @(negedge clk);
      bank_rsp_valid = 1'b0;
      for (int t = 0; t < SL; t++) if (act[t] && cnt[t] > 0) cnt[t]--;
      found = 1'b0;
      for (int t = SL - 1; t >= 0; t--) begin
        if (!found && act[t] && cnt[t] == 0) begin
          bank_rsp_valid = 1'b1;
          bank_rsp_tag   = 2'(t);
          bank_rsp_data  = qvec(adr[t]);
          act[t] = 1'b0;
          found  = 1'b1;
        end
      end
      bank_req_ready = !(bank_stall && (cyc % 5 == 3));
      #1;
      if (!rst && bank_req_valid && bank_req_ready) begin
        int t;
        int eq;
        t = int'(bank_req_tag);
        n_req++;
        check(!act[t], "R11 one outstanding per slot", 128'(act[t]), 128'(0));
        eq = (qexp[t].size() > 0) ? qexp[t].pop_front() : -1;
        check(int'(bank_req_addr) == eq, "R2/R4 bank addr for tag slot",
              128'(bank_req_addr), 128'(eq));
        act[t] = 1'b1;
        adr[t] = int'(bank_req_addr);
        cnt[t] = 1 + ((adr[t] + t * 3) % 6);
      end
    end
  end

  // Output monitor.
  initial begin
    bit           waiting = 1'b0;
    logic [127:0] held_d = '0;
    logic [1:0]   held_s = '0;
    forever begin
      @(negedge clk);
      ps_ready = !(out_stall && (cyc % 4 < 2));
      #1;
      if (waiting)
        check(ps_valid && ps_data == held_d && ps_slot == held_s, "R8 output held",
              ps_data, held_d);
      waiting = 1'b0;
      if (!rst && ps_valid && ps_ready) begin
        int s;
        logic [127:0] e;
        s = int'(ps_slot);
        e = (done_q[s].size() > 0) ? done_q[s].pop_front() : 128'hDEAD;
        check(ps_data == e, "R5/R6/R9 partial sum", ps_data, e);
        check(!act[s], "R7 offered after last data", 128'(act[s]), 128'(0));
      end else if (!rst && ps_valid) begin
        waiting = 1'b1;
        held_d  = ps_data;
        held_s  = ps_slot;
      end
    end
  end

  task automatic send(input int slot, input int idx, input bit last);
    int q;
    int r;
    bit rd;
    q = idx / 16;
    r = idx % 16;
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = {last, 2'(slot), 12'(idx)};
    while (1) begin
      #1;
      rd = instr_ready;
      @(posedge clk);
      if (rd) break;
      @(negedge clk);
    end
    qexp[slot].push_back(q);
    n_instr++;
    for (int l = 0; l < LN; l++)
      run_acc[slot][l*16 +: 16] = run_acc[slot][l*16 +: 16] + qlane(q, l) + rlane(r, l);
    if (last) begin
      done_q[slot].push_back(run_acc[slot]);
      run_acc[slot] = '0;
    end
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int left;
    left = 3000;
    while (left > 0) begin
      bit busy;
      @(negedge clk);
      busy = 1'b0;
      for (int s = 0; s < SL; s++) if (done_q[s].size() > 0 || act[s]) busy = 1'b1;
      if (!busy) break;
      left--;
    end
    check(left > 0, tag, 128'(left), 128'(1));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(!ps_valid && !bank_req_valid && instr_ready, "R1 reset state",
          {ps_valid, bank_req_valid, instr_ready}, 128'b001);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!ps_valid && !bank_req_valid && instr_ready, "R1 after release",
          {ps_valid, bank_req_valid, instr_ready}, 128'b001);
  endtask

  task automatic t_load;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      lut_we      = 1'b1;
      lut_addr    = 4'(r);
      lut_wdata   = rvec(r);
      instr_valid = 1'b1;
      instr_word  = {1'b1, 2'd0, 12'd5};
      #1;
      if (r % 4 == 0)
        check(!instr_ready, "R10 no instr during load", 128'(instr_ready), 128'(0));
    end
    @(negedge clk);
    lut_we      = 1'b0;
    instr_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(!bank_req_valid && !ps_valid, "R10 no effect of blocked instr",
          {bank_req_valid, ps_valid}, 128'(0));
  endtask

  task automatic t_single;
    // R2: index 0 -> q 0 r 0; 4095 -> q 255 r 15; 0x123 -> q 0x12 r 3.
    send(0, 0, 1'b0);
    send(0, 4095, 1'b0);
    send(0, 'h123, 1'b1);
    wait_drain("R5 single batch drained");
  endtask

  task automatic t_interleave;
    bank_stall = 1'b1;
    out_stall  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      for (int s = 0; s < SL; s++) begin
        if (i < 3 + s) send(s, (i * 701 + s * 389 + 17) % 4096, (i == 2 + s) || (i == 5 && s == 3));
      end
    end
    wait_drain("R6 interleaved slots drained");
    bank_stall = 1'b0;
    out_stall  = 1'b0;
  endtask

  task automatic t_reuse;
    out_stall = 1'b1;
    send(2, 77, 1'b1);
    send(2, 3000, 1'b0);
    send(2, 15, 1'b1);
    send(2, 4080, 1'b1);
    wait_drain("R9 slot reuse drained");
    out_stall = 1'b0;
  endtask

  task automatic t_burst;
    bank_stall = 1'b1;
    for (int i = 0; i < 10; i++) send(1, i * 409 + 4, i == 9);
    wait_drain("R11 same slot burst drained");
    bank_stall = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    for (int s = 0; s < SL; s++) run_acc[s] = '0;
    t_reset();
    t_load();
    t_single();
    t_interleave();
    t_reuse();
    t_burst();
    repeat (10) @(negedge clk);
    check(n_req == n_instr, "R3 one bank request per instruction", 128'(n_req), 128'(n_instr));
    done_flag = 1'b1;
    finish_run();
  end

endmodule